// File: doc/BRIEF.md
# Serial Divider-Word Loader

This block receives divider settings for a frequency synthesizer over a three-wire serial link: a data line, a data clock and a load strobe. Bits are shifted into an internal register on each rising edge of the data clock, most significant bit first. A rising edge on the load strobe copies the register into the output latches. The clock, data and strobe pins are asynchronous to the block clock `clk`. They pass through a synchronizer and are edge-detected inside the block, so every pin level must be held for at least two `clk` cycles.

In the default steered mode, the final bit of a frame chooses the destination. A 1 sends the preceding 14 bits to the reference divider value. A 0 sends the preceding 17 bits to the main divider value (10 bits) and the swallow count (7 bits). The serial pins have no handshake. The host paces the link itself and cannot be stalled, so the block accepts a bit on every detected clock edge.

Setting `FIXED_FRAME` selects a second variant. It takes a 19-bit frame with no steering bit. That frame carries two band-switch bits, then the main divider value, then the swallow count. The two switch bits drive open-drain outputs, which are modelled here as active-high output enables.

Top module: `synth_serial_loader`

## Requirements
- R1: Serial bits are taken on each rising edge of `ser_clk` and shifted in most significant bit first, so the first bit of a field ends up as that field's top bit.
- R2: Shifting data or clock edges with no rising edge on `ser_le` leaves `r_div`, `n_div`, `a_cnt` and `sw_oe` unchanged.
- R3: Steered mode, R frame (15 bits): 14 bits of R value, MSB first, then a steering bit of 1. On the strobe edge, `r_div` takes the 14-bit value, and `n_div` and `a_cnt` keep their values.
- R4: Steered mode, N/A frame (18 bits): 10 bits of N, then 7 bits of A, both MSB first, then a steering bit of 0. On the strobe edge, `n_div` and `a_cnt` load those fields, and `r_div` keeps its value.
- R5: A latched R or N value below 3 is stored as 3. An A value of 0 is stored as 0.
- R6: While `rst_n` is low, the outputs are `r_div`=3, `n_div`=3, `a_cnt`=0 and `sw_oe`=0 (both switches released).
- R7: Fixed-frame mode (19 bits, no steering bit): switch bit 1, switch bit 2, N (10 bits), A (7 bits). On the strobe edge, N and A load from the frame, and `r_div` stays at 3.
- R8: Switch encoding: a switch bit of 1 releases the output (`sw_oe` bit = 0), and a 0 pulls it low (`sw_oe` bit = 1). The first switch bit drives `sw_oe[0]` and the second drives `sw_oe[1]`. In steered mode `sw_oe` stays 0.
- R9: If `ser_le` goes high before rising `clk` edge k, the new values appear after edge k+2, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial data clock, asynchronous |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe, rising edge latches |
| r_div | output | R_W (14) | Reference divider value |
| n_div | output | N_W (10) | Main divider value |
| a_cnt | output | A_W (7) | Swallow count |
| sw_oe | output | 2 | Band-switch pull-low enables |

## Verification
The hardest case to reach is a frame misalignment that still produces a legal-looking value. Symmetric patterns hide a one-bit slip of the field boundaries. The stimulus therefore loads asymmetric values and field extremes (1, 2, 16383, 1023, 127) so that any slip or truncation changes the result. The latency window is a second difficult case. The bench raises the strobe and samples between each of the following clock edges to confirm that nothing moves before the third edge. A separate frame is shifted in fully without a strobe, to show that shift activity alone never reaches the outputs.

// File: rtl/synth_load_pkg.sv
package synth_load_pkg;
  // Steering bit meaning in the variable-length mode
  typedef enum logic {
    DEST_NA  = 1'b0,
    DEST_REF = 1'b1
  } dest_e;
endpackage

// File: rtl/sl_sync.sv
module sl_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= raw_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sl_shifter.sv
module sl_shifter #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)       word_o <= '0;
    else if (shift_i) word_o <= {word_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/sl_latch_bank.sv
module sl_latch_bank
  import synth_load_pkg::*;
#(
  parameter int R_W         = 14,
  parameter int N_W         = 10,
  parameter int A_W         = 7,
  parameter int MIN_DIV     = 3,
  parameter bit FIXED_FRAME = 1'b0,
  parameter int SR_W        = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [SR_W-1:0] word_i,
  output logic [R_W-1:0]  r_o,
  output logic [N_W-1:0]  n_o,
  output logic [A_W-1:0]  a_o,
  output logic [1:0]      sw_oe_o
);
  localparam int NA_W = N_W + A_W;
  localparam logic [R_W-1:0] R_FLOOR = R_W'(MIN_DIV);
  localparam logic [N_W-1:0] N_FLOOR = N_W'(MIN_DIV);

  function automatic logic [R_W-1:0] floor_r(input logic [R_W-1:0] v);
    return (v < R_FLOOR) ? R_FLOOR : v;
  endfunction

  function automatic logic [N_W-1:0] floor_n(input logic [N_W-1:0] v);
    return (v < N_FLOOR) ? N_FLOOR : v;
  endfunction

  if (!FIXED_FRAME) begin : g_steered
    dest_e          dest;
    logic [R_W-1:0] r_fld;
    logic [N_W-1:0] n_fld;
    logic [A_W-1:0] a_fld;

    assign dest  = dest_e'(word_i[0]);
    assign r_fld = word_i[R_W:1];
    assign n_fld = word_i[NA_W:A_W+1];
    assign a_fld = word_i[A_W:1];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r_o <= R_FLOOR;
        n_o <= N_FLOOR;
        a_o <= '0;
      end else if (load_i) begin
        if (dest == DEST_REF) begin
          r_o <= floor_r(r_fld);
        end else begin
          n_o <= floor_n(n_fld);
          a_o <= a_fld;
        end
      end
    end
    assign sw_oe_o = 2'b00;
  end else begin : g_fixed
    logic [N_W-1:0] n_fld;
    logic [A_W-1:0] a_fld;
    logic [1:0]     sw_fld;

    assign sw_fld = {word_i[NA_W], word_i[NA_W+1]};
    assign n_fld  = word_i[NA_W-1:A_W];
    assign a_fld  = word_i[A_W-1:0];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        n_o     <= N_FLOOR;
        a_o     <= '0;
        sw_oe_o <= 2'b00;
      end else if (load_i) begin
        n_o     <= floor_n(n_fld);
        a_o     <= a_fld;
        sw_oe_o <= ~sw_fld;
      end
    end
    assign r_o = R_FLOOR;
  end
endmodule

// File: rtl/synth_serial_loader.sv
module synth_serial_loader #(
  parameter int R_W         = 14,
  parameter int N_W         = 10,
  parameter int A_W         = 7,
  parameter int MIN_DIV     = 3,
  parameter bit FIXED_FRAME = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk,
  input  logic           ser_dat,
  input  logic           ser_le,
  output logic [R_W-1:0] r_div,
  output logic [N_W-1:0] n_div,
  output logic [A_W-1:0] a_cnt,
  output logic [1:0]     sw_oe
);
  localparam int NA_W    = N_W + A_W;
  localparam int STEER_W = ((R_W > NA_W) ? R_W : NA_W) + 1;
  localparam int SR_W    = FIXED_FRAME ? (NA_W + 2) : STEER_W;

  // pin order: [2] strobe, [1] data clock, [0] data
  logic [2:0]      pin_lvl;
  logic [1:0]      edge_q;
  logic            shift_pulse;
  logic            le_rise;
  logic [SR_W-1:0] sr_word;

  sl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({ser_le, ser_clk, ser_dat}),
    .sync_o (pin_lvl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) edge_q <= 2'b00;
    else        edge_q <= pin_lvl[2:1];
  end

  assign shift_pulse = pin_lvl[1] & ~edge_q[0];
  assign le_rise     = pin_lvl[2] & ~edge_q[1];

  sl_shifter #(.W(SR_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_i (shift_pulse),
    .bit_i   (pin_lvl[0]),
    .word_o  (sr_word)
  );

  sl_latch_bank #(
    .R_W(R_W), .N_W(N_W), .A_W(A_W), .MIN_DIV(MIN_DIV),
    .FIXED_FRAME(FIXED_FRAME), .SR_W(SR_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (le_rise),
    .word_i  (sr_word),
    .r_o     (r_div),
    .n_o     (n_div),
    .a_o     (a_cnt),
    .sw_oe_o (sw_oe)
  );
endmodule

// File: rtl/synth_serial_loader_chk.sv
module synth_serial_loader_chk #(
  parameter int R_W     = 14,
  parameter int N_W     = 10,
  parameter int A_W     = 7,
  parameter int MIN_DIV = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           le_rise,
  input logic [R_W-1:0] r_div,
  input logic [N_W-1:0] n_div,
  input logic [A_W-1:0] a_cnt,
  input logic [1:0]     sw_oe
);
  a_r5_r_floor: assert property (@(posedge clk) disable iff (!rst_n)
    r_div >= R_W'(MIN_DIV));

  a_r5_n_floor: assert property (@(posedge clk) disable iff (!rst_n)
    n_div >= N_W'(MIN_DIV));

  a_r2_hold_div: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(le_rise) |-> ($stable(r_div) && $stable(n_div) && $stable(a_cnt)));

  a_r2_hold_sw: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(le_rise) |-> $stable(sw_oe));
endmodule

bind synth_serial_loader synth_serial_loader_chk #(
  .R_W(R_W), .N_W(N_W), .A_W(A_W), .MIN_DIV(MIN_DIV)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .le_rise (le_rise),
  .r_div   (r_div),
  .n_div   (n_div),
  .a_cnt   (a_cnt),
  .sw_oe   (sw_oe)
);

// File: tb/tb_synth_serial_loader.sv
module tb_ref_model #(
  parameter bit FIXED = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic ck,
  input logic dt,
  input logic le
);
  // pin samples, newest first: {le, ck, dt}
  logic [2:0] seen[$];
  bit         bits[$];
  int         er = 3;
  int         en = 3;
  int         ea = 0;
  int         esw = 0;

  function automatic int field(int skip, int width);
    int v = 0;
    int top = bits.size() - 1 - skip;
    for (int k = width - 1; k >= 0; k--) v = (v << 1) | int'(bits[top - k]);
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      seen.delete();
      for (int i = 0; i < 4; i++) seen.push_back(3'b000);
      bits.delete();
      for (int i = 0; i < 19; i++) bits.push_back(1'b0);
      er = 3; en = 3; ea = 0; esw = 0;
    end else begin
      seen.push_front({le, ck, dt});
      void'(seen.pop_back());
      // the block acts on pin levels seen two edges ago
      if (seen[2][2] && !seen[3][2]) begin
        if (!FIXED) begin
          if (bits[bits.size()-1]) begin
            er = field(1, 14);
            if (er < 3) er = 3;
          end else begin
            ea = field(1, 7);
            en = field(8, 10);
            if (en < 3) en = 3;
          end
        end else begin
          ea = field(0, 7);
          en = field(7, 10);
          if (en < 3) en = 3;
          esw = (bits[bits.size()-18] ? 0 : 2) | (bits[bits.size()-19] ? 0 : 1);
        end
      end
      if (seen[2][1] && !seen[3][1]) begin
        bits.push_back(seen[2][0]);
        void'(bits.pop_front());
      end
    end
  end
endmodule

module tb_synth_serial_loader;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ckv = 2'b00;
  logic [1:0] dtv = 2'b00;
  logic [1:0] lev = 2'b00;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  logic [13:0] r0, r1;
  logic [9:0]  n0, n1;
  logic [6:0]  a0, a1;
  logic [1:0]  s0, s1;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_serial_loader dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ckv[0]), .ser_dat(dtv[0]), .ser_le(lev[0]),
    .r_div(r0), .n_div(n0), .a_cnt(a0), .sw_oe(s0)
  );

  synth_serial_loader #(.FIXED_FRAME(1'b1)) dut_fix (
    .clk(clk), .rst_n(rst_n), .ser_clk(ckv[1]), .ser_dat(dtv[1]), .ser_le(lev[1]),
    .r_div(r1), .n_div(n1), .a_cnt(a1), .sw_oe(s1)
  );

  tb_ref_model #(.FIXED(1'b0)) m0 (.clk(clk), .rst_n(rst_n), .ck(ckv[0]), .dt(dtv[0]), .le(lev[0]));
  tb_ref_model #(.FIXED(1'b1)) m1 (.clk(clk), .rst_n(rst_n), .ck(ckv[1]), .dt(dtv[1]), .le(lev[1]));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_out(input int u, input string tag, input int r, input int n, input int a, input int s);
    int ar = (u == 0) ? int'(r0) : int'(r1);
    int an = (u == 0) ? int'(n0) : int'(n1);
    int aa = (u == 0) ? int'(a0) : int'(a1);
    int as = (u == 0) ? int'(s0) : int'(s1);
    chk(ar == r, {tag, " r_div"}, ar, r);
    chk(an == n, {tag, " n_div"}, an, n);
    chk(aa == a, {tag, " a_cnt"}, aa, a);
    chk(as == s, {tag, " sw_oe"}, as, s);
  endtask

  // R9 and all fields: per-cycle comparison against the models
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(int'(r0) == m0.er, "R9 R3 cycle r_div", int'(r0), m0.er);
      chk(int'(n0) == m0.en, "R9 R4 cycle n_div", int'(n0), m0.en);
      chk(int'(a0) == m0.ea, "R9 R4 cycle a_cnt", int'(a0), m0.ea);
      chk(int'(s0) == m0.esw, "R8 cycle sw_oe", int'(s0), m0.esw);
      chk(int'(r1) == m1.er, "R7 cycle fixed r_div", int'(r1), m1.er);
      chk(int'(n1) == m1.en, "R7 cycle fixed n_div", int'(n1), m1.en);
      chk(int'(a1) == m1.ea, "R7 cycle fixed a_cnt", int'(a1), m1.ea);
      chk(int'(s1) == m1.esw, "R8 cycle fixed sw_oe", int'(s1), m1.esw);
    end
  end

  task automatic shift_word(input int u, input logic [31:0] w, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      dtv[u] = w[i];
      repeat (2) @(negedge clk);
      ckv[u] = 1'b1;
      repeat (3) @(negedge clk);
      ckv[u] = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic strobe(input int u);
    lev[u] = 1'b1;
    repeat (3) @(negedge clk);
    lev[u] = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic load_r(input int v);
    shift_word(0, (32'(v) << 1) | 32'd1, 15);
    strobe(0);
  endtask

  task automatic load_na(input int n, input int a);
    shift_word(0, (32'(n) << 8) | (32'(a) << 1), 18);
    strobe(0);
  endtask

  task automatic load_fix(input int sw1, input int sw2, input int n, input int a);
    shift_word(1, (32'(sw1) << 18) | (32'(sw2) << 17) | (32'(n) << 7) | 32'(a), 19);
    strobe(1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    expect_out(0, "R6 reset", 3, 3, 0, 0);
    expect_out(1, "R6 reset fixed", 3, 3, 0, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_out(0, "R6 after release", 3, 3, 0, 0);

    load_r(1000);
    expect_out(0, "R3 load ref", 1000, 3, 0, 0);
    load_r(14'h2A5B);
    expect_out(0, "R1 msb first", 14'h2A5B, 3, 0, 0);
    load_na(517, 45);
    expect_out(0, "R4 load n/a", 14'h2A5B, 517, 45, 0);
    load_na(1023, 127);
    expect_out(0, "R4 n/a max", 14'h2A5B, 1023, 127, 0);
    load_r(16383);
    expect_out(0, "R3 ref max", 16383, 1023, 127, 0);
    load_r(1);
    expect_out(0, "R5 ref floor 1", 3, 1023, 127, 0);
    load_r(2);
    expect_out(0, "R5 ref floor 2", 3, 1023, 127, 0);
    load_na(0, 0);
    expect_out(0, "R5 n floor a zero", 3, 3, 0, 0);
    load_na(3, 1);
    expect_out(0, "R5 n at floor", 3, 3, 1, 0);

    // R2: a complete frame with no strobe changes nothing
    shift_word(0, (32'd600 << 8) | (32'd9 << 1), 18);
    repeat (6) @(negedge clk);
    expect_out(0, "R2 no strobe", 3, 3, 1, 0);

    // R9: strobe latency, outputs move only after the third edge
    shift_word(0, (32'd700 << 1) | 32'd1, 15);
    lev[0] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(r0 == 14'd3, "R9 edge1 unchanged", int'(r0), 3);
    @(posedge clk);
    @(negedge clk);
    chk(r0 == 14'd3, "R9 edge2 unchanged", int'(r0), 3);
    @(posedge clk);
    @(negedge clk);
    chk(r0 == 14'd700, "R9 edge3 updated", int'(r0), 700);
    lev[0] = 1'b0;
    repeat (4) @(negedge clk);

    load_fix(0, 1, 100, 5);
    expect_out(1, "R7 R8 fixed frame a", 3, 100, 5, 1);
    load_fix(1, 0, 2, 127);
    expect_out(1, "R7 R8 fixed frame b", 3, 3, 127, 2);
    load_fix(1, 1, 1023, 0);
    expect_out(1, "R8 both released", 3, 1023, 0, 0);
    load_fix(0, 0, 345, 64);
    expect_out(1, "R8 both pulled", 3, 345, 64, 3);
    expect_out(0, "R8 steered sw idle", 700, 3, 1, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule